// File: doc/BRIEF.md
# Floating-Point Synchronous Exception Priority Reporter

This block sits at the commit point of an in-order floating-point pipeline. Each cycle it may see one committing instruction, the raw exception flags that instruction produced, and a live vector of per-type interrupt enables. A fixed priority over the exception types selects at most one enabled exception per instruction. That choice decides which flags are recorded in the sticky floating-point status word and whether an interrupt is taken.

Taking an interrupt saves the current machine state word and the next instruction address. It then loads a fixed handler vector into the fetch redirect and clears the external-interrupt enable and floating-point enable bits of the state word. A return strobe reverses this.

Instructions marked imprecise do not trap on commit. Their recorded flags collect in a pending set until a synchronizing event. The event then reports the whole set at once, into the syndrome word and the status word. If any of the pending types is enabled at that time, one interrupt is raised. A stall output holds issue behind long-latency divide and square-root operations while any exception type is enabled.

Top module: `fpx_reporter`

## Requirements
- R1: After reset, the state word equals MSR_RST (0xA3), the saved address, saved state, syndrome and status words are zero, and redirect_vld_o is low.
- R2: A precise committing instruction whose flags include an enabled type raises redirect_vld_o for exactly one cycle, in the cycle after commit. redirect_addr_o is then HANDLER_VEC (0x700) and exc_syn_o holds only the bit of the highest enabled flag. Bit NTYPE-1 is the highest priority.
- R3: For a committing instruction, every flag below the highest enabled flag is suppressed: it never reaches the status word or the pending set, whether its own type is enabled or not. Disabled flags above the winner are still recorded.
- R4: Disabled flags never cause or block an interrupt. A precise instruction with no enabled flag causes no redirect and ORs all its flags into fpsr_o.
- R5: Flags from a committing instruction with cmt_fp_i low (not computational, not a status writer) have no effect on fpsr_o, exc_syn_o or the redirect.
- R6: On interrupt entry, saved_nia_o takes nia_i and saved_msr_o takes the prior state word. The state word loses bit EE_BIT (1) and bit FE_BIT (0), and its other bits are kept.
- R7: Imprecise commits never redirect and do not touch fpsr_o. At sync_i, the pending set together with any same-cycle imprecise flags is ORed into fpsr_o. If any of those types is enabled, an interrupt is raised with exc_syn_o equal to the whole merged set. The pending set is then empty.
- R8: A synchronizing event whose merged set has no enabled type updates fpsr_o but raises no redirect.
- R9: When a precise interrupt and sync_i fall in the same cycle, the precise interrupt is taken and the pending set is kept for a later synchronizing event.
- R10: While redirect_vld_o is high, the commit, sync and return inputs are ignored, so redirect_vld_o is never high in two consecutive cycles.
- R11: flush_young_o is high in the cycle an interrupt is decided if young_vld_i is high in that cycle.
- R12: A return strobe restores the state word from saved_msr_o and redirects, one cycle later, to saved_nia_o.
- R13: stall_o is high exactly when long_busy_i is high and at least one exception type is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmt_vld_i | input | 1 | An instruction commits this cycle |
| cmt_fp_i | input | 1 | Committing instruction may raise FP exceptions |
| cmt_imp_i | input | 1 | Committing instruction's exceptions are imprecise |
| cmt_exc_i | input | NTYPE | Raw exception flags, bit NTYPE-1 highest priority |
| exc_en_i | input | NTYPE | Per-type interrupt enables |
| nia_i | input | AW | Next instruction address at the commit point |
| sync_i | input | 1 | Synchronizing event |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| young_vld_i | input | 1 | A younger instruction is valid this cycle |
| long_busy_i | input | 1 | Divide or square root in flight |
| msr_o | output | MW | Current machine state word |
| saved_nia_o | output | AW | Saved next instruction address |
| saved_msr_o | output | MW | Saved machine state word |
| redirect_vld_o | output | 1 | Fetch redirect, one cycle |
| redirect_addr_o | output | AW | Fetch redirect target |
| exc_syn_o | output | NTYPE | Syndrome of the last interrupt |
| fpsr_o | output | NTYPE | Sticky floating-point status flags |
| flush_young_o | output | 1 | Flush the younger instruction |
| stall_o | output | 1 | Hold issue |

## Verification
The bench sends mixed flag and enable patterns in which a disabled flag sits above the winner and an enabled or disabled flag sits below it. A picker that ranks in the wrong direction, or that lets disabled flags win, would set the wrong syndrome bit. A picker that fails to suppress lower flags would leak them into the status word.

Commits arriving while the redirect is high test that a second trap is not taken back to back. The imprecise path is tested with a flag merged in the same cycle as the synchronizing event, with a sync that has no enabled type (which must not trap), and with a sync that collides with a precise trap (where a wrong design would lose the pending set or report it early).

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_TRAP = 2'd1,
    RD_RET  = 2'd2
  } redir_kind_e;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
  parameter int NTYPE = 4
) (
  input  logic [NTYPE-1:0] act_i,
  input  logic [NTYPE-1:0] en_i,
  output logic [NTYPE-1:0] win_o,
  output logic [NTYPE-1:0] rec_o,
  output logic             hit_o
);
  logic [NTYPE-1:0] cand;
  logic             seen;

  assign cand  = act_i & en_i;
  assign hit_o = |cand;

  // walk from highest priority; everything below the first enabled hit is masked
  always_comb begin
    seen  = 1'b0;
    win_o = '0;
    rec_o = '0;
    for (int i = NTYPE - 1; i >= 0; i--) begin
      win_o[i] = cand[i] & ~seen;
      rec_o[i] = act_i[i] & ~seen;
      seen     = seen | cand[i];
    end
  end
endmodule

// File: rtl/fpx_imp_acc.sv
module fpx_imp_acc #(
  parameter int NTYPE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTYPE-1:0] add_i,
  input  logic             sync_i,
  input  logic [NTYPE-1:0] en_i,
  output logic [NTYPE-1:0] merged_o,
  output logic             irq_o
);
  logic [NTYPE-1:0] pend_q;

  assign merged_o = pend_q | add_i;
  assign irq_o    = sync_i & |(merged_o & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (sync_i) pend_q <= '0;
    else             pend_q <= merged_o;
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> pend_q == '0);
endmodule

// File: rtl/fpx_intr_ctl.sv
module fpx_intr_ctl
  import fpx_pkg::*;
#(
  parameter int              AW          = 32,
  parameter int              MW          = 8,
  parameter int              EE_BIT      = 1,
  parameter int              FE_BIT      = 0,
  parameter logic [MW-1:0]   MSR_RST     = 8'hA3,
  parameter logic [AW-1:0]   HANDLER_VEC = 32'h0000_0700
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          rfi_i,
  input  logic [AW-1:0] nia_i,
  output logic [MW-1:0] msr_o,
  output logic [AW-1:0] saved_nia_o,
  output logic [MW-1:0] saved_msr_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_addr_o
);
  localparam logic [MW-1:0] CLR_MASK = ~((MW'(1) << EE_BIT) | (MW'(1) << FE_BIT));

  redir_kind_e kind;

  always_comb begin
    if (take_i)     kind = RD_TRAP;
    else if (rfi_i) kind = RD_RET;
    else            kind = RD_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_o        <= MSR_RST;
      saved_nia_o  <= '0;
      saved_msr_o  <= '0;
      redir_vld_o  <= 1'b0;
      redir_addr_o <= '0;
    end else begin
      redir_vld_o <= (kind != RD_NONE);
      unique case (kind)
        RD_TRAP: begin
          saved_nia_o  <= nia_i;
          saved_msr_o  <= msr_o;
          msr_o        <= msr_o & CLR_MASK;
          redir_addr_o <= HANDLER_VEC;
        end
        RD_RET: begin
          msr_o        <= saved_msr_o;
          redir_addr_o <= saved_nia_o;
        end
        default: ;
      endcase
    end
  end

  // R6
  entry_msr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !msr_o[EE_BIT] && !msr_o[FE_BIT] && saved_msr_o == $past(msr_o));
  // R6
  entry_nia_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> saved_nia_o == $past(nia_i) && redir_addr_o == HANDLER_VEC);
  // R12
  ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !take_i) |=> msr_o == $past(saved_msr_o) && redir_vld_o);
endmodule

// File: rtl/fpx_reporter.sv
module fpx_reporter #(
  parameter int                NTYPE       = 4,
  parameter int                AW          = 32,
  parameter int                MW          = 8,
  parameter int                EE_BIT      = 1,
  parameter int                FE_BIT      = 0,
  parameter logic [MW-1:0]     MSR_RST     = 8'hA3,
  parameter logic [AW-1:0]     HANDLER_VEC = 32'h0000_0700
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmt_vld_i,
  input  logic             cmt_fp_i,
  input  logic             cmt_imp_i,
  input  logic [NTYPE-1:0] cmt_exc_i,
  input  logic [NTYPE-1:0] exc_en_i,
  input  logic [AW-1:0]    nia_i,
  input  logic             sync_i,
  input  logic             rfi_i,
  input  logic             young_vld_i,
  input  logic             long_busy_i,
  output logic [MW-1:0]    msr_o,
  output logic [AW-1:0]    saved_nia_o,
  output logic [MW-1:0]    saved_msr_o,
  output logic             redirect_vld_o,
  output logic [AW-1:0]    redirect_addr_o,
  output logic [NTYPE-1:0] exc_syn_o,
  output logic [NTYPE-1:0] fpsr_o,
  output logic             flush_young_o,
  output logic             stall_o
);
  logic             busy;
  logic             cmt_ok;
  logic [NTYPE-1:0] act;
  logic [NTYPE-1:0] win;
  logic [NTYPE-1:0] rec;
  logic             hit;
  logic             prec_take;
  logic [NTYPE-1:0] imp_add;
  logic             sync_eff;
  logic [NTYPE-1:0] merged;
  logic             sync_irq;
  logic             take;
  logic             rfi_eff;

  // cycle after a redirect: younger work is gone, inputs are dropped
  assign busy   = redirect_vld_o;
  assign cmt_ok = cmt_vld_i & cmt_fp_i & ~busy;
  assign act    = cmt_ok ? cmt_exc_i : '0;

  fpx_prio_pick #(.NTYPE(NTYPE)) i_pick (
    .act_i (act),
    .en_i  (exc_en_i),
    .win_o (win),
    .rec_o (rec),
    .hit_o (hit)
  );

  assign prec_take = hit & ~cmt_imp_i;
  assign imp_add   = cmt_imp_i ? rec : '0;
  assign sync_eff  = sync_i & ~busy & ~prec_take;

  fpx_imp_acc #(.NTYPE(NTYPE)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .add_i    (imp_add),
    .sync_i   (sync_eff),
    .en_i     (exc_en_i),
    .merged_o (merged),
    .irq_o    (sync_irq)
  );

  assign take    = prec_take | sync_irq;
  assign rfi_eff = rfi_i & ~busy;

  fpx_intr_ctl #(
    .AW(AW), .MW(MW), .EE_BIT(EE_BIT), .FE_BIT(FE_BIT),
    .MSR_RST(MSR_RST), .HANDLER_VEC(HANDLER_VEC)
  ) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .rfi_i        (rfi_eff),
    .nia_i        (nia_i),
    .msr_o        (msr_o),
    .saved_nia_o  (saved_nia_o),
    .saved_msr_o  (saved_msr_o),
    .redir_vld_o  (redirect_vld_o),
    .redir_addr_o (redirect_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_syn_o <= '0;
      fpsr_o    <= '0;
    end else begin
      if (prec_take)     exc_syn_o <= win;
      else if (sync_irq) exc_syn_o <= merged;
      fpsr_o <= fpsr_o | (cmt_imp_i ? '0 : rec) | (sync_eff ? merged : '0);
    end
  end

  assign flush_young_o = take & young_vld_i;
  assign stall_o       = long_busy_i & |exc_en_i;

  // R10
  redir_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_vld_o |=> !redirect_vld_o);
  // R2
  syn_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prec_take |=> $onehot(exc_syn_o) && redirect_vld_o);
  // R5
  nonfp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_vld_i && !cmt_fp_i && !sync_i) |=> $stable(fpsr_o));
  // R7
  imp_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_imp_i && !sync_i && !rfi_i) |=> !redirect_vld_o);
endmodule

// File: tb/test_fpx_reporter.sv
module test_fpx_reporter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmt_vld = 0, cmt_fp = 0, cmt_imp = 0, sync = 0, rfi = 0, young = 0, lbusy = 0;
  logic [3:0]  cmt_exc = '0, exc_en = '0;
  logic [31:0] nia = '0;
  logic [7:0]  msr, smsr;
  logic [31:0] snia, raddr;
  logic        rvld, flush, stall;
  logic [3:0]  syn, fpsr;
  int          n_chk = 0, n_err = 0;
  logic [3:0]  fp_exp = '0;

  always #10 clk = ~clk;

  fpx_reporter i_fpx_reporter (
    .clk_i(clk), .rst_ni(rst_n), .cmt_vld_i(cmt_vld), .cmt_fp_i(cmt_fp),
    .cmt_imp_i(cmt_imp), .cmt_exc_i(cmt_exc), .exc_en_i(exc_en), .nia_i(nia),
    .sync_i(sync), .rfi_i(rfi), .young_vld_i(young), .long_busy_i(lbusy),
    .msr_o(msr), .saved_nia_o(snia), .saved_msr_o(smsr), .redirect_vld_o(rvld),
    .redirect_addr_o(raddr), .exc_syn_o(syn), .fpsr_o(fpsr),
    .flush_young_o(flush), .stall_o(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cmt_vld = 0; cmt_fp = 0; cmt_imp = 0; sync = 0; rfi = 0; young = 0;
    cmt_exc = '0; exc_en = '0;
  endtask

  task automatic commit(input logic imp, input logic [3:0] exc, input logic [3:0] en);
    cmt_vld = 1; cmt_fp = 1; cmt_imp = imp; cmt_exc = exc; exc_en = en;
  endtask

  task automatic t_reset();
    chk("R1 msr", msr, 8'hA3);
    chk("R1 saved", {snia[7:0], smsr}, 16'h0);
    chk("R1 syn/fpsr", {syn, fpsr}, 8'h0);
    chk("R1 redirect", rvld, 0);
  endtask

  task automatic t_precise();
    // bit3 disabled above winner bit1, bit0 enabled below: suppressed
    commit(0, 4'b1011, 4'b0011); nia = 32'h100; young = 1;
    #1 chk("R11 flush", flush, 1);
    step();
    fp_exp |= 4'b1010;
    chk("R2 redirect", rvld, 1);
    chk("R2 vector", raddr, 32'h700);
    chk("R2 syndrome", syn, 4'b0010);
    chk("R3 fpsr", fpsr, fp_exp);
    chk("R6 saved nia", snia, 32'h100);
    chk("R6 saved msr", smsr, 8'hA3);
    chk("R6 msr", msr, 8'hA0);
    // commit during redirect cycle must be ignored
    commit(0, 4'b0001, 4'b1111); young = 1;
    #1 chk("R10 no flush", flush, 0);
    step();
    chk("R10 redirect drop", rvld, 0);
    chk("R10 syndrome kept", syn, 4'b0010);
    chk("R10 fpsr kept", fpsr, fp_exp);
    idle();
  endtask

  task automatic t_rfi();
    rfi = 1;
    step();
    rfi = 0;
    chk("R12 redirect", rvld, 1);
    chk("R12 addr", raddr, 32'h100);
    chk("R12 msr", msr, 8'hA3);
    step();
  endtask

  task automatic t_disabled();
    commit(0, 4'b0110, 4'b0001);
    step();
    idle();
    fp_exp |= 4'b0110;
    chk("R4 no redirect", rvld, 0);
    chk("R4 fpsr", fpsr, fp_exp);
  endtask

  task automatic t_nonfp();
    commit(0, 4'b1111, 4'b1111); cmt_fp = 0;
    step();
    idle();
    chk("R5 no redirect", rvld, 0);
    chk("R5 fpsr", fpsr, fp_exp);
    chk("R5 syndrome", syn, 4'b0010);
  endtask

  task automatic t_imprecise();
    commit(1, 4'b0101, 4'b0100);
    step();
    chk("R7 no trap", rvld, 0);
    chk("R7 fpsr untouched", fpsr, fp_exp);
    commit(1, 4'b1000, 4'b0000);
    step();
    chk("R7 no trap 2", rvld, 0);
    commit(1, 4'b0001, 4'b0100); cmt_exc = 4'b0001; exc_en = 4'b0000;
    sync = 1; exc_en = 4'b0100; cmt_exc = 4'b0001; nia = 32'h240;
    // imprecise commit: cand=0, rec=0001; merged = 0100|1000|0001
    step();
    idle();
    fp_exp |= 4'b1101;
    chk("R7 redirect", rvld, 1);
    chk("R7 syndrome", syn, 4'b1101);
    chk("R7 fpsr", fpsr, fp_exp);
    chk("R7 saved nia", snia, 32'h240);
    step();
  endtask

  task automatic t_sync_none();
    commit(1, 4'b0010, 4'b0000);
    step();
    idle();
    sync = 1;
    step();
    idle();
    chk("R8 no redirect", rvld, 0);
    chk("R8 fpsr", fpsr, fp_exp);
    chk("R8 syndrome kept", syn, 4'b1101);
  endtask

  task automatic t_collide();
    // fpsr already holds every bit, so track via syndrome
    commit(1, 4'b0001, 4'b0000);
    step();
    commit(0, 4'b1000, 4'b1001); sync = 1;
    step();
    idle();
    chk("R9 precise wins", syn, 4'b1000);
    chk("R9 redirect", rvld, 1);
    step();
    sync = 1; exc_en = 4'b0001;
    step();
    idle();
    chk("R9 pending later", syn, 4'b0001);
    chk("R9 redirect later", rvld, 1);
    step();
  endtask

  task automatic t_stall();
    lbusy = 1; exc_en = 4'b0000;
    #1 chk("R13 no enable", stall, 0);
    exc_en = 4'b0100;
    #1 chk("R13 stall", stall, 1);
    lbusy = 0;
    #1 chk("R13 idle", stall, 0);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_precise();
        t_rfi();
        t_disabled();
        t_nonfp();
        t_imprecise();
        t_sync_none();
        t_collide();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule